// File: doc/BRIEF.md
# Multi-View Gated FIFO Cell

A single FIFO cell used for communication between the threads of a multithreaded core. One memory-mapped request port reaches the same storage through four access views. A two-bit view select picks the view. Each view has its own rules for blocking, for ignoring an access and for changing the cell state.

A request carries a view select, a read/write flag, a thread number and write data. One cycle later the cell answers with exactly one of two strobes. The done strobe, with read data, means the access was served. The block strobe means the issuing thread must stall and retry. Threads that are stalled are tracked in per-thread waiting bits. When the condition that stalled them clears, those bits are dropped and a wake pulse carries the mask of released threads.

Top module: `gated_fifo_cell`

## Requirements
- R1: After reset the cell is empty, no thread is waiting, and rsp_done, rsp_block and wake_valid are all low.
- R2: In the synchronized view (code 2) and the non-blocking view (code 3), a write pushes its data and a read pops the oldest entry. Data leave in arrival order, and occupancy never exceeds DEPTH.
- R3: A read in the tag view (code 0) returns the tag word. Bit 0 is Empty, bit 1 is Full, bit 2 is a read-only FIFO-type bit that is always 1, and the field starting at bit 8 is the occupancy. All other bits read 0.
- R4: A synchronized-view read while the cell is empty is blocked. It leaves the storage unchanged and sets the issuing thread's waiting bit.
- R5: A synchronized-view write while the cell is full is blocked. It leaves the storage unchanged and sets the issuing thread's waiting bit.
- R6: The non-blocking view never blocks. A write to a full cell is dropped, and a read from an empty cell returns 0.
- R7: The bypass view (code 1) never blocks and never changes the occupancy. A read returns the oldest entry without removing it, and a write replaces the newest entry.
- R8: A tag-view write with bit 0 set empties the cell. In any other tag-view write, the bits written have no effect.
- R9: Waiting bits are released in the same cycle the cell state changes. Readers are released when the cell becomes non-empty, and writers when it becomes non-full. The released threads appear together in wake_mask with wake_valid high, one cycle after the request that caused the change.
- R10: A retry from a thread whose waiting bit is set is blocked again while its condition holds. It is served once the condition allows, and a served synchronized request clears that thread's waiting bit.
- R11: Every accepted request (req_valid high at a clock edge) produces exactly one of rsp_done or rsp_block in the following cycle. No strobe appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_view | input | 2 | Access view: 0 tag, 1 bypass, 2 synchronized, 3 non-blocking |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_tid | input | TID_W | Issuing thread number |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | Request served (one-cycle pulse) |
| rsp_block | output | 1 | Request stalled; the thread must retry (one-cycle pulse) |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_done |
| wake_valid | output | 1 | One or more waiting threads released |
| wake_mask | output | THREADS | Threads released this cycle |
| wait_map | output | THREADS | Threads currently waiting on the cell |

## Verification
The bench builds the cell with DEPTH 4, THREADS 4 and 32-bit data. At these sizes full and empty are reached within a handful of pushes, and every thread number occurs often. A long pseudo-random run therefore visits each view from the empty, partial and full states, and repeatedly crosses both wake conditions. A small arithmetic queue model in the bench predicts every strobe, data word, wake mask and waiting map. Directed sequences before the run pin down the tag layout, flush, retry and drop cases.

// File: rtl/gfc_pkg.sv
package gfc_pkg;
   typedef enum logic [1:0] {
      VIEW_CTRL   = 2'd0,
      VIEW_BYPASS = 2'd1,
      VIEW_SYNC   = 2'd2,
      VIEW_TRY    = 2'd3
   } view_e;

   localparam int TAG_EMPTY_BIT = 0;
   localparam int TAG_FULL_BIT  = 1;
   localparam int TAG_TYPE_BIT  = 2;
   localparam int TAG_CNT_LSB   = 8;
endpackage

// File: rtl/gfc_store.sv
module gfc_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 4,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic              flush,
   input  logic              ovw,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] head,
   output logic [CNT_W-1:0]  cnt,
   output logic [CNT_W-1:0]  cnt_nx
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, newest;

   initial begin : chk_params
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("gfc_store: DEPTH must be a power of two, at least 2");
   end

   assign head   = mem[rd_ptr];
   assign newest = wr_ptr - PTR_W'(1);

   always_comb begin
      if (flush)     cnt_nx = '0;
      else if (push) cnt_nx = cnt + CNT_W'(1);
      else if (pop)  cnt_nx = cnt - CNT_W'(1);
      else           cnt_nx = cnt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         cnt <= cnt_nx;
         if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
         end else begin
            if (push) begin
               mem[wr_ptr] <= wdata;
               wr_ptr      <= wr_ptr + PTR_W'(1);
            end
            if (pop) rd_ptr <= rd_ptr + PTR_W'(1);
            if (ovw) mem[newest] <= wdata;
         end
      end
   end

   assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH));
   assert_push_room_R2: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> cnt != CNT_W'(DEPTH));
   assert_pop_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> cnt != '0);
endmodule

// File: rtl/gfc_waitmap.sv
module gfc_waitmap #(
   parameter int THREADS = 4,
   localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [TID_W-1:0]   tid,
   input  logic               set_rd,
   input  logic               set_wr,
   input  logic               serve,
   input  logic               data_ok,
   input  logic               space_ok,
   output logic [THREADS-1:0] wait_rd,
   output logic [THREADS-1:0] wait_wr,
   output logic               wake_valid,
   output logic [THREADS-1:0] wake_mask
);
   logic [THREADS-1:0] rd_d, wr_d, wk_d;

   initial begin : chk_params
      assert (THREADS >= 1) else $error("gfc_waitmap: THREADS must be at least 1");
   end

   for (genvar i = 0; i < THREADS; i++) begin : g_thr
      logic hit, keep_rd, keep_wr;
      assign hit     = (tid == TID_W'(i));
      assign keep_rd = wait_rd[i] & ~(serve & hit);
      assign keep_wr = wait_wr[i] & ~(serve & hit);
      assign rd_d[i] = ~data_ok  & (keep_rd | (set_rd & hit));
      assign wr_d[i] = ~space_ok & (keep_wr | (set_wr & hit));
      assign wk_d[i] = (keep_rd & data_ok) | (keep_wr & space_ok);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wait_rd    <= '0;
         wait_wr    <= '0;
         wake_valid <= 1'b0;
         wake_mask  <= '0;
      end else begin
         wait_rd    <= rd_d;
         wait_wr    <= wr_d;
         wake_valid <= |wk_d;
         wake_mask  <= wk_d;
      end
   end

   assert_wake_subset_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wake_valid |-> (wake_mask & ~$past(wait_rd | wait_wr)) == '0);
   assert_wake_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wake_valid |-> (wake_mask & (wait_rd | wait_wr)) == '0);
endmodule

// File: rtl/gated_fifo_cell.sv
module gated_fifo_cell
   import gfc_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int DEPTH   = 4,
   parameter int THREADS = 4,
   localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [1:0]         req_view,
   input  logic               req_write,
   input  logic [TID_W-1:0]   req_tid,
   input  logic [DATA_W-1:0]  req_wdata,
   output logic               rsp_done,
   output logic               rsp_block,
   output logic [DATA_W-1:0]  rsp_rdata,
   output logic               wake_valid,
   output logic [THREADS-1:0] wake_mask,
   output logic [THREADS-1:0] wait_map
);
   view_e              view;
   logic [CNT_W-1:0]   cnt, cnt_nx;
   logic [DATA_W-1:0]  head, tag, rd_nx;
   logic               is_ef, empty, full;
   logic               do_push, do_pop, do_flush, do_ovw, stall, served_sync;
   logic [THREADS-1:0] wait_rd, wait_wr;

   initial begin : chk_params
      assert (DATA_W >= TAG_CNT_LSB + CNT_W)
         else $error("gated_fifo_cell: DATA_W too narrow for the tag word");
   end

   assign view = view_e'(req_view);

   always_comb begin
      is_ef       = (view == VIEW_SYNC) || (view == VIEW_TRY);
      empty       = (cnt == '0);
      full        = (cnt == CNT_W'(DEPTH));
      do_push     = req_valid && req_write && is_ef && !full;
      do_pop      = req_valid && !req_write && is_ef && !empty;
      do_flush    = req_valid && req_write && (view == VIEW_CTRL) && req_wdata[TAG_EMPTY_BIT];
      do_ovw      = req_valid && req_write && (view == VIEW_BYPASS);
      stall       = req_valid && (view == VIEW_SYNC) && (req_write ? full : empty);
      served_sync = req_valid && (view == VIEW_SYNC) && !stall;

      tag                          = '0;
      tag[TAG_EMPTY_BIT]           = empty;
      tag[TAG_FULL_BIT]            = full;
      tag[TAG_TYPE_BIT]            = 1'b1;
      tag[TAG_CNT_LSB +: CNT_W]    = cnt;

      rd_nx = '0;
      if (!req_write) begin
         case (view)
            VIEW_CTRL:   rd_nx = tag;
            VIEW_BYPASS: rd_nx = head;
            default:     rd_nx = empty ? '0 : head;
         endcase
      end
   end

   gfc_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .push   (do_push),
      .pop    (do_pop),
      .flush  (do_flush),
      .ovw    (do_ovw),
      .wdata  (req_wdata),
      .head   (head),
      .cnt    (cnt),
      .cnt_nx (cnt_nx)
   );

   gfc_waitmap #(.THREADS(THREADS)) u_wait (
      .clk        (clk),
      .rst_n      (rst_n),
      .tid        (req_tid),
      .set_rd     (stall && !req_write),
      .set_wr     (stall && req_write),
      .serve      (served_sync),
      .data_ok    (cnt_nx != '0),
      .space_ok   (cnt_nx != CNT_W'(DEPTH)),
      .wait_rd    (wait_rd),
      .wait_wr    (wait_wr),
      .wake_valid (wake_valid),
      .wake_mask  (wake_mask)
   );

   assign wait_map = wait_rd | wait_wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_done  <= 1'b0;
         rsp_block <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_done  <= req_valid && !stall;
         rsp_block <= stall;
         rsp_rdata <= (req_valid && !stall) ? rd_nx : '0;
      end
   end

   assert_one_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (rsp_done ^ rsp_block));
   assert_no_spurious_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !(rsp_done || rsp_block));
   assert_try_noblock_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_view == VIEW_TRY) |=> !rsp_block);
   assert_bypass_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_view == VIEW_BYPASS) |=> $stable(cnt));
   assert_rdwait_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|wait_rd) |-> cnt == '0);
   assert_wrwait_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|wait_wr) |-> cnt == CNT_W'(DEPTH));
endmodule

// File: tb/tb_gated_fifo_cell.sv
module tb_gated_fifo_cell;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;
   localparam int DP = 4;
   localparam int NT = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_view = '0;
   logic          req_write = 1'b0;
   logic [1:0]    req_tid = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          rsp_done, rsp_block, wake_valid;
   logic [DW-1:0] rsp_rdata;
   logic [NT-1:0] wake_mask, wait_map;

   int total = 0;
   int bad = 0;

   logic [DW-1:0] mq [8];
   int            mcnt = 0;
   logic [NT-1:0] mrd = '0, mwr = '0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   gated_fifo_cell #(.DATA_W(DW), .DEPTH(DP), .THREADS(NT)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_view(req_view),
      .req_write(req_write), .req_tid(req_tid), .req_wdata(req_wdata),
      .rsp_done(rsp_done), .rsp_block(rsp_block), .rsp_rdata(rsp_rdata),
      .wake_valid(wake_valid), .wake_mask(wake_mask), .wait_map(wait_map)
   );

   task automatic check(input bit ok, input string rq, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] model_tag();
      logic [DW-1:0] t = '0;
      t[0] = (mcnt == 0);
      t[1] = (mcnt == DP);
      t[2] = 1'b1;
      t[8 +: 3] = 3'(mcnt);
      return t;
   endfunction

   task automatic model_pop(output logic [DW-1:0] v);
      v = mq[0];
      for (int i = 0; i < 7; i++) mq[i] = mq[i + 1];
      mcnt--;
   endtask

   task automatic do_op(input logic [1:0] v, input logic w, input int t,
                        input logic [DW-1:0] d, input string rq);
      logic          e_done = 1'b1;
      logic [DW-1:0] e_rd = '0;
      logic [NT-1:0] e_wk = '0;
      bit            chk_rd = 1'b1;
      case (v)
         2'd0: if (w) begin if (d[0]) mcnt = 0; end else e_rd = model_tag();
         2'd1: if (w) begin if (mcnt > 0) mq[mcnt - 1] = d; end
               else if (mcnt > 0) e_rd = mq[0]; else chk_rd = 1'b0;
         2'd2: if (w) begin
                  if (mcnt == DP) begin e_done = 1'b0; mwr[t] = 1'b1; end
                  else begin mq[mcnt] = d; mcnt++; mrd[t] = 1'b0; mwr[t] = 1'b0; end
               end else begin
                  if (mcnt == 0) begin e_done = 1'b0; mrd[t] = 1'b1; end
                  else begin model_pop(e_rd); mrd[t] = 1'b0; mwr[t] = 1'b0; end
               end
         default: if (w) begin if (mcnt < DP) begin mq[mcnt] = d; mcnt++; end end
                  else if (mcnt > 0) model_pop(e_rd);
      endcase
      if (mcnt != 0)  begin e_wk |= mrd; mrd = '0; end
      if (mcnt != DP) begin e_wk |= mwr; mwr = '0; end

      @(negedge clk);
      req_valid = 1'b1; req_view = v; req_write = w; req_tid = 2'(t); req_wdata = d;
      @(posedge clk);
      #1;
      req_valid = 1'b0;
      check(rsp_done == e_done && rsp_block == !e_done, "R11", {rq, " done/block"},
            {30'd0, rsp_block, rsp_done}, {30'd0, !e_done, e_done});
      if (e_done && chk_rd) check(rsp_rdata == e_rd, rq, "rdata", rsp_rdata, e_rd);
      check(wake_valid == (|e_wk) && wake_mask == e_wk, "R9", "wake",
            {27'd0, wake_valid, wake_mask}, {27'd0, |e_wk, e_wk});
      check(wait_map == (mrd | mwr), "R10", "wait map", DW'(wait_map), DW'(mrd | mwr));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [31:0] r = 32'h1234_5678;
      logic [DW-1:0] dd;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;
      // R1: idle outputs after reset
      check(!rsp_done && !rsp_block && !wake_valid && wait_map == '0, "R1", "reset outputs",
            {28'd0, rsp_done, rsp_block, wake_valid, |wait_map}, '0);
      do_op(2'd0, 1'b0, 0, '0, "R1");                 // tag empty after reset
      do_op(2'd0, 1'b1, 0, 32'h0000_0706, "R8");      // no flush bit: no effect
      do_op(2'd0, 1'b0, 0, '0, "R3");                 // tag unchanged, type bit 1
      do_op(2'd2, 1'b0, 1, '0, "R4");                 // sync read empty: block
      do_op(2'd2, 1'b0, 1, '0, "R10");                // retry still blocked
      do_op(2'd2, 1'b1, 0, 32'hA0, "R2");             // push wakes thread 1 (R9)
      do_op(2'd3, 1'b1, 2, 32'hA1, "R2");
      do_op(2'd3, 1'b1, 2, 32'hA2, "R2");
      do_op(2'd2, 1'b1, 3, 32'hA3, "R2");
      do_op(2'd0, 1'b0, 0, '0, "R3");                 // full tag, count 4
      do_op(2'd2, 1'b1, 3, 32'hB0, "R5");             // sync write full: block
      do_op(2'd2, 1'b1, 3, 32'hB0, "R10");            // retry blocked
      do_op(2'd3, 1'b1, 1, 32'hB1, "R6");             // try write full: dropped
      do_op(2'd1, 1'b0, 2, '0, "R7");                 // bypass read oldest
      do_op(2'd1, 1'b1, 2, 32'hC3, "R7");             // bypass write newest
      do_op(2'd0, 1'b0, 0, '0, "R7");                 // count unchanged
      do_op(2'd3, 1'b0, 2, '0, "R2");                 // pop A0, wakes thread 3
      do_op(2'd2, 1'b1, 3, 32'hB0, "R10");            // retry served
      for (int i = 0; i < 4; i++) do_op(2'd2, 1'b0, i, '0, "R2"); // A1 A2 C3 B0
      do_op(2'd3, 1'b0, 0, '0, "R6");                 // try read empty: 0
      do_op(2'd3, 1'b1, 0, 32'hD0, "R2");
      do_op(2'd0, 1'b1, 1, 32'h1, "R8");              // flush
      do_op(2'd0, 1'b0, 0, '0, "R8");
      for (int k = 0; k < 1500; k++) begin
         r ^= r << 13; r ^= r >> 17; r ^= r << 5;
         dd = r;
         if (r[1:0] == 2'd0 && r[2]) dd[0] = (r[7:5] == 3'd0);
         case (r[1:0])
            2'd0: do_op(r[1:0], r[2], int'(r[4:3]), dd, "R8");
            2'd1: do_op(r[1:0], r[2], int'(r[4:3]), dd, "R7");
            2'd2: do_op(r[1:0], r[2], int'(r[4:3]), dd, "R4");
            default: do_op(r[1:0], r[2], int'(r[4:3]), dd, "R6");
         endcase
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule